// File: doc/BRIEF.md
# MESI Read-Cycle State Controller

This block decides how a second-level cache controller answers a processor read. Each read names a line index. The block looks up that line's MESI state and its read-only marker, then combines them with the read's attributes: locked, uncacheable, write-through, and data versus code. From these it chooses one of four memory bus actions. It also sets the processor-side cache-enable and write-through controls, and it writes the line's new state back into a small per-line state array.

A hit is resolved in one cycle. A read to an invalid line waits until memory signals that its cycle is complete. The memory-side attributes arriving in that same cycle then fix the outcome: cacheable, read-only, forced write-through, or direct-to-modified. Each finished read produces a one-cycle result pulse carrying the bus action, the control bits and the new line state. Tag comparison, data transfer, snooping and writes are handled elsewhere.

Top module: `mesi_read_ctrl`

## Requirements
- R1: After reset `busy` and `res_vld` are low. Every line is invalid with its read-only marker clear. Line state is encoded I=00, S=01, E=10, M=11. An invalid line never holds a set read-only marker.
- R2: A non-locked read to a line in M gives bus action none, cache-enable 1 and write-through 0, and the line stays M.
- R3: A locked read to a line in M, E or S gives a read-through bus action with cache-enable 0 and write-through 1, and the state is unchanged. `res_from_arr` is 1 only when the line was M.
- R4: A non-locked read to a line in E gives bus action none, cache-enable 1 and write-through 0, and the line stays E. A non-locked read to an S line with its read-only marker clear gives bus action none, cache-enable 1 and write-through 1, and the line stays S.
- R5: A non-locked read to an S line with its read-only marker set keeps the line S with the marker set. Cache-enable is 0 for a data read (`rd_is_data`=1) and 1 for a code read.
- R6: A read to an invalid line raises `busy` from the next cycle until the cycle after `fill_done`. While `busy` is high, `rd_req` is ignored and no result is produced. A `fill_done` seen while not busy is ignored.
- R7: A miss that is uncached, locked, or for which memory reports it not cacheable at `fill_done` gives a non-cacheable read with cache-enable 0. The line stays invalid.
- R8: A cacheable miss with memory read-only set gives a line fill. The line goes to S with its read-only marker set, and cache-enable is 1 for a code read and 0 for a data read.
- R9: A cacheable miss with memory read-only clear and either the request or memory write-through set gives a line fill to S. Write-through is 1, cache-enable is 1 and the marker is clear.
- R10: A cacheable miss with memory read-only and both write-through flags clear gives a line fill. The line goes to E with write-through 0 when `mem_to_mod` is 0, and to M with write-through 1 when it is 1. The marker is clear in both cases.
- R11: Bus action is encoded none=00, read-through=01, non-cacheable read=10, line fill=11. `res_vld` is high for exactly the one cycle after the accepting edge of a hit, or after the `fill_done` edge of a miss, and the result fields are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request strobe |
| rd_line | input | IDX_W | Line index of the read |
| rd_locked | input | 1 | Read is part of a locked sequence |
| rd_nocache | input | 1 | Processor marks the read uncacheable |
| rd_wthru | input | 1 | Processor requests write-through |
| rd_is_data | input | 1 | 1 for a data read, 0 for a code read |
| fill_done | input | 1 | Memory cycle for a pending miss is complete |
| mem_cacheable | input | 1 | Memory allows caching (sampled with fill_done) |
| mem_rdonly | input | 1 | Memory marks the line read-only |
| mem_wthru | input | 1 | Memory forces write-through |
| mem_to_mod | input | 1 | Memory allows a direct move to M |
| busy | output | 1 | A miss is waiting for fill_done |
| res_vld | output | 1 | One-cycle result pulse |
| res_cyc | output | 2 | Bus action of the finished read |
| res_ken | output | 1 | Processor cache-enable |
| res_wt | output | 1 | Processor write-through |
| res_from_arr | output | 1 | Read-through data comes from the local array |
| res_state | output | 2 | New state of the line |
| res_tro | output | 1 | New read-only marker of the line |

## Verification
The bench builds the block with `LINES` = 8, so the top index 7 is reached as easily as index 0. That line count lets a single run fill most lines through a different miss path and then reread each one. The rereads cover every hit branch, including locked reads out of M, E and S and both data and code reads of a read-only S line. They also check that a read sent while a miss is pending leaves the named line untouched.

// File: rtl/mesi_rd_pkg.sv
package mesi_rd_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    CYC_NONE = 2'b00,
    CYC_RTHR = 2'b01,
    CYC_NCRD = 2'b10,
    CYC_FILL = 2'b11
  } bus_cyc_e;

  typedef struct packed {
    logic locked;
    logic nocache;
    logic wthru;
    logic is_data;
  } rd_attr_t;

  typedef struct packed {
    logic cacheable;
    logic rdonly;
    logic wthru;
    logic to_mod;
  } mem_attr_t;

  typedef struct packed {
    bus_cyc_e cyc;
    logic     ken;
    logic     wt;
    logic     from_arr;
    line_st_e st;
    logic     tro;
  } rd_dec_t;

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_rd_pkg::*;
#(
  parameter int LINES = 16,
  parameter int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  output line_st_e         look_st,
  output logic             look_tro,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_st_e         wr_st,
  input  logic             wr_tro
);

  line_st_e st_q  [LINES];
  logic     tro_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g]  <= ST_I;
        tro_q[g] <= 1'b0;
      end else if (sel) begin
        st_q[g]  <= wr_st;
        tro_q[g] <= wr_tro;
      end
    end

    // R1: an invalid line never carries the read-only marker
    assert_inv_clears_tro_R1 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (st_q[g] == ST_I) |-> !tro_q[g]);
  end

  assign look_st  = st_q[look_idx];
  assign look_tro = tro_q[look_idx];

endmodule

// File: rtl/mesi_rd_policy.sv
module mesi_rd_policy
  import mesi_rd_pkg::*;
(
  input  line_st_e  cur_st,
  input  logic      cur_tro,
  input  rd_attr_t  req,
  input  mem_attr_t mem,
  output rd_dec_t   dec
);

  always_comb begin
    dec.cyc      = CYC_NONE;
    dec.ken      = 1'b1;
    dec.wt       = 1'b1;
    dec.from_arr = 1'b0;
    dec.st       = cur_st;
    dec.tro      = cur_tro;
    unique case (cur_st)
      ST_M: begin
        if (req.locked) begin
          dec.cyc      = CYC_RTHR;
          dec.ken      = 1'b0;
          dec.from_arr = 1'b1;
        end else begin
          dec.wt = 1'b0;
        end
      end
      ST_E: begin
        if (req.locked) begin
          dec.cyc = CYC_RTHR;
          dec.ken = 1'b0;
        end else begin
          dec.wt = 1'b0;
        end
      end
      ST_S: begin
        if (req.locked) begin
          dec.cyc = CYC_RTHR;
          dec.ken = 1'b0;
        end else if (cur_tro) begin
          dec.ken = !req.is_data;
        end
      end
      default: begin
        dec.tro = 1'b0;
        if (req.nocache || req.locked || !mem.cacheable) begin
          dec.cyc = CYC_NCRD;
          dec.ken = 1'b0;
          dec.st  = ST_I;
        end else begin
          dec.cyc = CYC_FILL;
          if (mem.rdonly) begin
            dec.st  = ST_S;
            dec.tro = 1'b1;
            dec.ken = !req.is_data;
          end else if (req.wthru || mem.wthru) begin
            dec.st = ST_S;
          end else if (mem.to_mod) begin
            dec.st = ST_M;
          end else begin
            dec.st = ST_E;
            dec.wt = 1'b0;
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/mesi_rd_seq.sv
module mesi_rd_seq
  import mesi_rd_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_line,
  input  rd_attr_t         rd_attr,
  input  logic             fill_done,
  input  line_st_e         cur_st,
  input  rd_dec_t          dec,
  output logic [IDX_W-1:0] look_idx,
  output rd_attr_t         pol_attr,
  output logic             wr_en,
  output logic             busy,
  output logic             res_vld,
  output rd_dec_t          res
);

  typedef enum logic {PH_IDLE = 1'b0, PH_WAIT = 1'b1} phase_e;

  phase_e           ph_q, ph_d;
  logic [IDX_W-1:0] cap_line_q, cap_line_d;
  rd_attr_t         cap_attr_q, cap_attr_d;
  rd_dec_t          res_q, res_d;
  logic             vld_q, vld_d;
  logic             hit_now, miss_now, done_now, commit;

  always_comb begin
    hit_now  = (ph_q == PH_IDLE) && rd_req && (cur_st != ST_I);
    miss_now = (ph_q == PH_IDLE) && rd_req && (cur_st == ST_I);
    done_now = (ph_q == PH_WAIT) && fill_done;
    commit   = hit_now || done_now;

    look_idx = (ph_q == PH_WAIT) ? cap_line_q : rd_line;
    pol_attr = (ph_q == PH_WAIT) ? cap_attr_q : rd_attr;

    ph_d = ph_q;
    if (miss_now)      ph_d = PH_WAIT;
    else if (done_now) ph_d = PH_IDLE;

    cap_line_d = miss_now ? rd_line : cap_line_q;
    cap_attr_d = miss_now ? rd_attr : cap_attr_q;
    res_d      = commit ? dec : res_q;
    vld_d      = commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      cap_line_q <= '0;
      cap_attr_q <= '0;
      res_q      <= '0;
      vld_q      <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      cap_line_q <= cap_line_d;
      cap_attr_q <= cap_attr_d;
      res_q      <= res_d;
      vld_q      <= vld_d;
    end
  end

  assign wr_en   = commit;
  assign busy    = (ph_q == PH_WAIT);
  assign res_vld = vld_q;
  assign res     = res_q;

endmodule

// File: rtl/mesi_read_ctrl.sv
module mesi_read_ctrl
  import mesi_rd_pkg::*;
#(
  parameter int LINES = 16,
  parameter int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_line,
  input  logic             rd_locked,
  input  logic             rd_nocache,
  input  logic             rd_wthru,
  input  logic             rd_is_data,
  input  logic             fill_done,
  input  logic             mem_cacheable,
  input  logic             mem_rdonly,
  input  logic             mem_wthru,
  input  logic             mem_to_mod,
  output logic             busy,
  output logic             res_vld,
  output logic [1:0]       res_cyc,
  output logic             res_ken,
  output logic             res_wt,
  output logic             res_from_arr,
  output logic [1:0]       res_state,
  output logic             res_tro
);

  rd_attr_t         req_attr, pol_attr;
  mem_attr_t        mem_attr;
  rd_dec_t          dec, res;
  line_st_e         cur_st;
  logic             cur_tro;
  logic [IDX_W-1:0] look_idx;
  logic             wr_en;

  assign req_attr = '{locked: rd_locked, nocache: rd_nocache,
                      wthru: rd_wthru, is_data: rd_is_data};
  assign mem_attr = '{cacheable: mem_cacheable, rdonly: mem_rdonly,
                      wthru: mem_wthru, to_mod: mem_to_mod};

  mesi_line_array #(.LINES(LINES), .IDX_W(IDX_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_idx (look_idx),
    .look_st  (cur_st),
    .look_tro (cur_tro),
    .wr_en    (wr_en),
    .wr_idx   (look_idx),
    .wr_st    (dec.st),
    .wr_tro   (dec.tro)
  );

  mesi_rd_policy u_policy (
    .cur_st  (cur_st),
    .cur_tro (cur_tro),
    .req     (pol_attr),
    .mem     (mem_attr),
    .dec     (dec)
  );

  mesi_rd_seq #(.IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_line   (rd_line),
    .rd_attr   (req_attr),
    .fill_done (fill_done),
    .cur_st    (cur_st),
    .dec       (dec),
    .look_idx  (look_idx),
    .pol_attr  (pol_attr),
    .wr_en     (wr_en),
    .busy      (busy),
    .res_vld   (res_vld),
    .res       (res)
  );

  assign res_cyc      = res.cyc;
  assign res_ken      = res.ken;
  assign res_wt       = res.wt;
  assign res_from_arr = res.from_arr;
  assign res_state    = res.st;
  assign res_tro      = res.tro;

  assert_no_result_while_busy_R6 : assert property (
    @(posedge clk) disable iff (!rst_n) busy |-> !res_vld);

  assert_wait_until_fill_R6 : assert property (
    @(posedge clk) disable iff (!rst_n) (busy && !fill_done) |=> busy);

  assert_rthr_blocks_l1_R3 : assert property (
    @(posedge clk) disable iff (!rst_n)
    (res_vld && res_cyc == CYC_RTHR) |-> (!res_ken && res_wt && res_state != ST_I));

  assert_noncache_stays_inv_R7 : assert property (
    @(posedge clk) disable iff (!rst_n)
    (res_vld && res_cyc == CYC_NCRD) |-> (res_state == ST_I && !res_ken));

  assert_fill_makes_valid_R8 : assert property (
    @(posedge clk) disable iff (!rst_n)
    (res_vld && res_cyc == CYC_FILL) |-> (res_state != ST_I));

  assert_marker_only_in_s_R5 : assert property (
    @(posedge clk) disable iff (!rst_n)
    (res_vld && res_tro) |-> (res_state == ST_S));

  assert_mfill_keeps_wt_R10 : assert property (
    @(posedge clk) disable iff (!rst_n)
    (res_vld && res_cyc == CYC_FILL && res_state == ST_M) |-> res_wt);

  assert_hit_has_no_bus_R4 : assert property (
    @(posedge clk) disable iff (!rst_n)
    (res_vld && res_cyc == CYC_NONE) |-> (res_state != ST_I && !res_from_arr));

endmodule

// File: tb/sim_mesi_read_ctrl.sv
module sim_mesi_read_ctrl;

  localparam int LINES = 8;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_req = 0, rd_locked = 0, rd_nocache = 0, rd_wthru = 0, rd_is_data = 0;
  logic [IW-1:0] rd_line = '0;
  logic          fill_done = 0, mem_cacheable = 0, mem_rdonly = 0, mem_wthru = 0, mem_to_mod = 0;
  logic          busy, res_vld, res_ken, res_wt, res_from_arr, res_tro;
  logic [1:0]    res_cyc, res_state;

  mesi_read_ctrl #(.LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_line(rd_line),
    .rd_locked(rd_locked), .rd_nocache(rd_nocache), .rd_wthru(rd_wthru),
    .rd_is_data(rd_is_data), .fill_done(fill_done), .mem_cacheable(mem_cacheable),
    .mem_rdonly(mem_rdonly), .mem_wthru(mem_wthru), .mem_to_mod(mem_to_mod),
    .busy(busy), .res_vld(res_vld), .res_cyc(res_cyc), .res_ken(res_ken),
    .res_wt(res_wt), .res_from_arr(res_from_arr), .res_state(res_state), .res_tro(res_tro)
  );

  always #10 clk = ~clk;

  int n_checks = 0, n_fail = 0, cycles = 0;

  // behavioural reference
  int       m_st [LINES];
  bit       m_tro[LINES];
  bit       m_busy;
  int       c_line;
  bit       c_lk, c_nc, c_wt, c_dat;
  bit       e_vld;
  logic [7:0] e_vec;
  string    e_tag;

  function automatic logic [7:0] pack(int cyc, bit ken, bit wt, bit arr, int st, bit tro);
    return {cyc[1:0], ken, wt, arr, st[1:0], tro};
  endfunction

  task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tro[i] = 0; end
      m_busy = 0; e_vld = 0; e_vec = '0;
    end else if (!m_busy && rd_req) begin
      int l; int s; bit t;
      l = int'(rd_line); s = m_st[l]; t = m_tro[l];
      if (s == 0) begin
        m_busy = 1; c_line = l; c_lk = rd_locked; c_nc = rd_nocache;
        c_wt = rd_wthru; c_dat = rd_is_data; e_vld = 0;
      end else begin
        e_vld = 1;
        if (rd_locked)    begin e_vec = pack(1, 0, 1, s == 3, s, t); e_tag = "R3"; end
        else if (s == 3)  begin e_vec = pack(0, 1, 0, 0, 3, t);      e_tag = "R2"; end
        else if (s == 2)  begin e_vec = pack(0, 1, 0, 0, 2, t);      e_tag = "R4"; end
        else if (t)       begin e_vec = pack(0, !rd_is_data, 1, 0, 1, 1); e_tag = "R5"; end
        else              begin e_vec = pack(0, 1, 1, 0, 1, 0);      e_tag = "R4"; end
      end
    end else if (m_busy && fill_done) begin
      e_vld = 1; m_busy = 0;
      if (c_nc || c_lk || !mem_cacheable) begin e_vec = pack(2, 0, 1, 0, 0, 0); e_tag = "R7"; end
      else if (mem_rdonly)            begin e_vec = pack(3, !c_dat, 1, 0, 1, 1); e_tag = "R8"; end
      else if (c_wt || mem_wthru)     begin e_vec = pack(3, 1, 1, 0, 1, 0); e_tag = "R9"; end
      else if (mem_to_mod)            begin e_vec = pack(3, 1, 1, 0, 3, 0); e_tag = "R10"; end
      else                            begin e_vec = pack(3, 1, 0, 0, 2, 0); e_tag = "R10"; end
      m_st[c_line] = int'(e_vec[2:1]); m_tro[c_line] = e_vec[0];
    end else begin
      e_vld = 0;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      logic [7:0] act;
      act = {res_cyc, res_ken, res_wt, res_from_arr, res_state, res_tro};
      check(busy == m_busy, "R6 busy", {7'd0, busy}, {7'd0, m_busy});
      check(res_vld == e_vld, "R11 valid pulse", {7'd0, res_vld}, {7'd0, e_vld});
      if (e_vld && res_vld) check(act == e_vec, e_tag, act, e_vec);
    end
    if (cycles > 5000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic rd(int line, bit lk, bit nc, bit wt, bit dat);
    rd_req = 1; rd_line = IW'(line); rd_locked = lk; rd_nocache = nc;
    rd_wthru = wt; rd_is_data = dat;
    @(negedge clk);
    rd_req = 0; rd_locked = 0; rd_nocache = 0; rd_wthru = 0;
  endtask

  task automatic fill(int dly, bit ck, bit ro, bit mw, bit tm);
    repeat (dly) @(negedge clk);
    fill_done = 1; mem_cacheable = ck; mem_rdonly = ro; mem_wthru = mw; mem_to_mod = tm;
    @(negedge clk);
    fill_done = 0; mem_cacheable = 0; mem_rdonly = 0; mem_wthru = 0; mem_to_mod = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(busy == 0 && res_vld == 0, "R1 reset outputs", {6'd0, busy, res_vld}, 8'd0);
    rst_n = 1;
    @(negedge clk);

    rd(0, 0, 1, 0, 1); fill(0, 1, 0, 0, 0);   // R7 uncached
    rd(1, 1, 0, 0, 1); fill(2, 1, 0, 0, 0);   // R7 locked, R6 long wait
    rd(2, 0, 0, 0, 1); fill(0, 0, 0, 0, 0);   // R7 memory not cacheable
    rd(3, 0, 0, 0, 1); fill(1, 1, 1, 0, 0);   // R8 data read-only
    rd(3, 0, 0, 0, 1); @(negedge clk);        // R5 data
    rd(3, 0, 0, 0, 0); @(negedge clk);        // R5 code
    rd(3, 1, 0, 0, 1); @(negedge clk);        // R3 S
    rd(4, 0, 0, 0, 0); fill(0, 1, 1, 0, 0);   // R8 code read-only
    rd(4, 0, 0, 0, 0); @(negedge clk);        // R5 code
    rd(5, 0, 0, 1, 1); fill(0, 1, 0, 0, 0);   // R9 request write-through
    rd(5, 0, 0, 0, 1); @(negedge clk);        // R4 S
    rd(6, 0, 0, 0, 1); fill(0, 1, 0, 1, 0);   // R9 memory write-through
    rd(7, 0, 0, 0, 1); fill(1, 1, 0, 0, 0);   // R10 to E, top line
    rd(7, 0, 0, 0, 1); @(negedge clk);        // R4 E
    rd(7, 1, 0, 0, 1); @(negedge clk);        // R3 E
    rd(1, 0, 0, 0, 1); fill(0, 1, 0, 0, 1);   // R10 to M
    rd(1, 0, 0, 0, 1); @(negedge clk);        // R2
    rd(1, 1, 0, 0, 1); @(negedge clk);        // R3 M from array
    // R6: request during a pending miss is ignored
    rd(0, 0, 0, 0, 1);
    rd(2, 0, 0, 0, 1);
    fill(1, 1, 0, 0, 0);                      // line 0 to E
    rd(2, 0, 0, 0, 1); fill(0, 1, 0, 1, 0);   // line 2 was still invalid
    // R6: stray fill_done while idle
    fill(0, 1, 0, 0, 1);
    // back-to-back hits
    rd(7, 0, 0, 0, 1); rd(1, 0, 0, 0, 1); rd(3, 0, 0, 0, 0); rd(0, 1, 0, 0, 1);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule